// File: doc/BRIEF.md
# Command/Response Buffer Control Register Block

This block is the register front end of a trusted-module command/response buffer interface. Software reaches it over a simple byte-addressable bus that carries reads and writes of one to four bytes. It holds identity and buffer-descriptor words that are fixed at reset. It also holds locality status, control status, and the request, start and cancel control words. Writes to the control words do not store the written value. Instead they trigger actions: set or clear a status bit, or issue a strobe to a command-processing backend.

A start write launches a command. The block sets its busy bit, emits a single request strobe and presents the command length. That length is the smallest of the command header length, the backend buffer size and the command window size. While the command runs, a cancel write forwards a cancel strobe to the backend. When the backend reports completion, the busy bit clears by itself. If the completion carries an error, a sticky fatal-error status bit is set. The backend engine and the shared command/response memory are outside this block.

Top module: `crb_regs`

## Requirements
- R1: A 4-byte aligned write of value 1 to the start word (byte offset 0x4C) while start bit 0 is clear sets start bit 0 and raises `req_stb` for exactly one cycle, starting in the cycle after the write edge.
- R2: While start bit 0 is set, further start writes produce no request strobe and leave the start word unchanged.
- R3: A 4-byte aligned write of value 1 to the cancel word (offset 0x48) raises `cancel_stb` for one cycle only while start bit 0 is set. Otherwise it has no effect.
- R4: A completion (`cmp_valid`) clears start bit 0. A completion with `cmp_err` high sets the fatal bit (bit 0 of control status, offset 0x44), and the bit stays set until reset.
- R5: Writing 1 to the control-request word (offset 0x40) clears the idle bit (bit 1 of control status). Writing 2 sets that bit. Every other value leaves it unchanged. The idle bit is 0 after reset.
- R6: Writing 1 to the locality-control word (offset 0x08) sets the granted bit (bit 0) and clears the seized bit (bit 1) of locality status (offset 0x0C). It also sets the register-valid bit (bit 0) and the assigned bit (bit 1) of locality state (offset 0x00).
- R7: Any other locality-control value, including 2, 4 and 8, changes nothing.
- R8: The interface-ID word (offset 0x30) reads 0x00025811. Its fields are: type=1 in [3:0], version=1 in [7:4], locality-0-only=0 in [8], idle-bypass=0 in [9], transfer-size code 3 in [12:11], FIFO=0 in [13], buffer-interface=1 in [14], selector=1 in [18:17], and revision=0 in [31:24].
- R9: Reads are little-endian. A read at byte offset k within a word returns that word shifted right by 8*k bits.
- R10: After reset, the command and response size words (offsets 0x58 and 0x60) read WIN_SIZE-BUF_OFS (0xF80 by default). The command and response address words (offsets 0x5C and 0x64) read BASE_ADDR+BUF_OFS (0xFED40080 by default).
- R11: `req_len` equals min(`hdr_len`, min(`be_buf_size`, WIN_SIZE-BUF_OFS)), sampled at the start write.
- R12: A control action needs a 4-byte access (`bus_size`=3) at an aligned address with an exact value match. Writes to read-only or undefined offsets are dropped, and reads of undefined offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_size | input | 2 | Access size minus one (0..3 = 1..4 bytes) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| hdr_len | input | LEN_W | Length field from the command header |
| be_buf_size | input | LEN_W | Backend buffer size |
| req_stb | output | 1 | One-cycle command request to the backend |
| req_len | output | LEN_W | Length delivered with the request |
| cancel_stb | output | 1 | One-cycle cancel to the backend |
| cmp_valid | input | 1 | Backend completion |
| cmp_err | input | 1 | Completion carries an error |

## Verification
The hardest situation to reach is a start or cancel write that arrives while a command is in flight, with the completion still held back. The bench creates it by never raising `cmp_valid` on its own. It issues the start, then sends repeated start writes and cancel writes, and only afterwards releases the completion with a chosen error flag. The same flow runs over a grid of header and buffer lengths that straddles the window size, so every branch of the length minimum is taken.

// File: rtl/crb_pkg.sv
package crb_pkg;
   // word indices (byte offset / 4)
   localparam int unsigned W_LOC_STATE = 0;
   localparam int unsigned W_LOC_CTRL  = 2;
   localparam int unsigned W_LOC_STS   = 3;
   localparam int unsigned W_INTF_ID   = 12;
   localparam int unsigned W_CTRL_REQ  = 16;
   localparam int unsigned W_CTRL_STS  = 17;
   localparam int unsigned W_CANCEL    = 18;
   localparam int unsigned W_START     = 19;
   localparam int unsigned W_CMD_SIZE  = 22;
   localparam int unsigned W_CMD_ADDR  = 23;
   localparam int unsigned W_RSP_SIZE  = 24;
   localparam int unsigned W_RSP_ADDR  = 25;

   // action values
   localparam logic [31:0] V_ONE  = 32'd1;
   localparam logic [31:0] V_IDLE = 32'd2;

   // identity word fields
   localparam logic [3:0] ID_TYPE    = 4'd1;
   localparam logic [3:0] ID_VERSION = 4'd1;
   localparam logic [1:0] ID_XFER    = 2'd3;
   localparam logic       ID_BUFIF   = 1'b1;
   localparam logic [1:0] ID_SEL     = 2'd1;
   localparam logic [7:0] ID_REV     = 8'd0;

   function automatic logic [31:0] intf_id_word();
      logic [31:0] w;
      w        = '0;
      w[3:0]   = ID_TYPE;
      w[7:4]   = ID_VERSION;
      w[12:11] = ID_XFER;
      w[14]    = ID_BUFIF;
      w[18:17] = ID_SEL;
      w[31:24] = ID_REV;
      return w;
   endfunction

   typedef struct packed {
      logic start;
      logic cancel;
      logic cmd_ready;
      logic go_idle;
      logic loc_req;
   } crb_act_t;
endpackage

// File: rtl/crb_bus_decode.sv
module crb_bus_decode
   import crb_pkg::*;
#(
   parameter int unsigned ADDR_W = 7
) (
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [31:0]       bus_wdata,
   output crb_act_t          act
);
   localparam int unsigned WIDX_W = ADDR_W - 2;

   logic              full_wr;
   logic [WIDX_W-1:0] widx;

   assign widx    = bus_addr[ADDR_W-1:2];
   assign full_wr = bus_wr && (bus_size == 2'd3) && (bus_addr[1:0] == 2'b00);

   always_comb begin
      act           = '0;
      act.start     = full_wr && (widx == WIDX_W'(W_START))    && (bus_wdata == V_ONE);
      act.cancel    = full_wr && (widx == WIDX_W'(W_CANCEL))   && (bus_wdata == V_ONE);
      act.cmd_ready = full_wr && (widx == WIDX_W'(W_CTRL_REQ)) && (bus_wdata == V_ONE);
      act.go_idle   = full_wr && (widx == WIDX_W'(W_CTRL_REQ)) && (bus_wdata == V_IDLE);
      act.loc_req   = full_wr && (widx == WIDX_W'(W_LOC_CTRL)) && (bus_wdata == V_ONE);
   end
endmodule

// File: rtl/crb_cmd_ctrl.sv
module crb_cmd_ctrl #(
   parameter int unsigned LEN_W    = 16,
   parameter int unsigned CMD_SIZE = 3968
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_start,
   input  logic             go_cancel,
   input  logic             cmp_valid,
   input  logic             cmp_err,
   input  logic [LEN_W-1:0] hdr_len,
   input  logic [LEN_W-1:0] be_buf_size,
   output logic             busy,
   output logic             fatal,
   output logic             req_stb,
   output logic [LEN_W-1:0] req_len,
   output logic             cancel_stb
);
   localparam logic [LEN_W-1:0] CMD_SZ_L = LEN_W'(CMD_SIZE);

   logic [LEN_W-1:0] eff_size;
   logic [LEN_W-1:0] len_next;
   logic             launch;

   assign eff_size = (be_buf_size < CMD_SZ_L) ? be_buf_size : CMD_SZ_L;
   assign len_next = (hdr_len < eff_size) ? hdr_len : eff_size;
   assign launch   = go_start && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         fatal      <= 1'b0;
         req_stb    <= 1'b0;
         cancel_stb <= 1'b0;
         req_len    <= '0;
      end else begin
         req_stb    <= launch;
         cancel_stb <= go_cancel && busy;
         if (launch) begin
            busy    <= 1'b1;
            req_len <= len_next;
         end else if (cmp_valid) begin
            busy    <= 1'b0;
         end
         if (cmp_valid && cmp_err) fatal <= 1'b1;
      end
   end
endmodule

// File: rtl/crb_status_regs.sv
module crb_status_regs (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_ready,
   input  logic go_idle,
   input  logic loc_req,
   output logic idle,
   output logic granted,
   output logic seized,
   output logic assigned,
   output logic reg_valid
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle      <= 1'b0;
         granted   <= 1'b0;
         seized    <= 1'b0;
         assigned  <= 1'b0;
         reg_valid <= 1'b0;
      end else begin
         if (cmd_ready)    idle <= 1'b0;
         else if (go_idle) idle <= 1'b1;
         if (loc_req) begin
            granted   <= 1'b1;
            seized    <= 1'b0;
            assigned  <= 1'b1;
            reg_valid <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/crb_regs.sv
module crb_regs
   import crb_pkg::*;
#(
   parameter int unsigned ADDR_W    = 7,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned WIN_SIZE  = 4096,
   parameter int unsigned BUF_OFS   = 128,
   parameter logic [31:0] BASE_ADDR = 32'hFED4_0000,
   parameter bit          RD_PIPE   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [1:0]        bus_size,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [LEN_W-1:0]  hdr_len,
   input  logic [LEN_W-1:0]  be_buf_size,
   output logic              req_stb,
   output logic [LEN_W-1:0]  req_len,
   output logic              cancel_stb,
   input  logic              cmp_valid,
   input  logic              cmp_err
);
   localparam int unsigned CMD_SIZE = WIN_SIZE - BUF_OFS;
   localparam logic [31:0] BUF_ADDR = BASE_ADDR + 32'(BUF_OFS);
   localparam int unsigned WIDX_W   = ADDR_W - 2;

   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W must cover offsets up to 0x64");
   end
   if (BUF_OFS >= WIN_SIZE) begin : g_bad_ofs
      $error("BUF_OFS must lie inside the window");
   end
   if (CMD_SIZE >= (64'd1 << LEN_W)) begin : g_bad_len
      $error("LEN_W too narrow for the command size");
   end

   crb_act_t act;
   logic busy, fatal;
   logic idle, granted, seized, assigned, reg_valid;

   crb_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_size  (bus_size),
      .bus_wdata (bus_wdata),
      .act       (act)
   );

   crb_cmd_ctrl #(.LEN_W(LEN_W), .CMD_SIZE(CMD_SIZE)) u_cmd (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_start    (act.start),
      .go_cancel   (act.cancel),
      .cmp_valid   (cmp_valid),
      .cmp_err     (cmp_err),
      .hdr_len     (hdr_len),
      .be_buf_size (be_buf_size),
      .busy        (busy),
      .fatal       (fatal),
      .req_stb     (req_stb),
      .req_len     (req_len),
      .cancel_stb  (cancel_stb)
   );

   crb_status_regs u_sts (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_ready (act.cmd_ready),
      .go_idle   (act.go_idle),
      .loc_req   (act.loc_req),
      .idle      (idle),
      .granted   (granted),
      .seized    (seized),
      .assigned  (assigned),
      .reg_valid (reg_valid)
   );

   logic [WIDX_W-1:0] widx;
   logic [31:0]       word;
   logic [31:0]       rd_next;

   assign widx = bus_addr[ADDR_W-1:2];

   always_comb begin
      word = '0;
      case (widx)
         WIDX_W'(W_LOC_STATE): word = {30'd0, assigned, reg_valid};
         WIDX_W'(W_LOC_STS):   word = {30'd0, seized, granted};
         WIDX_W'(W_INTF_ID):   word = intf_id_word();
         WIDX_W'(W_CTRL_STS):  word = {30'd0, idle, fatal};
         WIDX_W'(W_START):     word = {31'd0, busy};
         WIDX_W'(W_CMD_SIZE):  word = 32'(CMD_SIZE);
         WIDX_W'(W_CMD_ADDR):  word = BUF_ADDR;
         WIDX_W'(W_RSP_SIZE):  word = 32'(CMD_SIZE);
         WIDX_W'(W_RSP_ADDR):  word = BUF_ADDR;
         default:              word = '0;
      endcase
      rd_next = word >> {bus_addr[1:0], 3'b000};
   end

   if (RD_PIPE) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) bus_rdata <= '0;
         else        bus_rdata <= rd_next;
      end
   end else begin : g_rd_comb
      assign bus_rdata = rd_next;
   end
endmodule

// File: rtl/crb_regs_chk.sv
module crb_regs_chk #(
   parameter int unsigned LEN_W    = 16,
   parameter int unsigned CMD_SIZE = 3968
) (
   input logic             clk,
   input logic             rst_n,
   input logic             go_start,
   input logic             go_cancel,
   input logic             busy,
   input logic             fatal,
   input logic             req_stb,
   input logic [LEN_W-1:0] req_len,
   input logic             cancel_stb,
   input logic             cmp_valid,
   input logic             cmp_err
);
   // R1
   a_r1_start_issues_req: assert property (@(posedge clk) disable iff (!rst_n)
      (go_start && !busy) |=> (req_stb && busy));

   // R2
   a_r2_busy_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !req_stb);

   // R3
   a_r3_cancel_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !cancel_stb);

   a_r3_cancel_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
      (go_cancel && busy) |=> cancel_stb);

   // R4
   a_r4_cmp_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && busy) |=> !busy);

   a_r4_err_sets_fatal: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && cmp_err) |=> fatal);

   a_r4_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fatal |=> fatal);

   // R11
   a_r11_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      req_stb |-> (req_len <= LEN_W'(CMD_SIZE)));

   // R1 single strobe
   a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      req_stb |=> !req_stb);
endmodule

bind crb_regs crb_regs_chk #(.LEN_W(LEN_W), .CMD_SIZE(CMD_SIZE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .go_start   (act.start),
   .go_cancel  (act.cancel),
   .busy       (busy),
   .fatal      (fatal),
   .req_stb    (req_stb),
   .req_len    (req_len),
   .cancel_stb (cancel_stb),
   .cmp_valid  (cmp_valid),
   .cmp_err    (cmp_err)
);

// File: tb/tb_crb_regs.sv
`timescale 1ns/1ps
module tb_crb_regs;
   localparam int ADDR_W = 7;
   localparam int LEN_W  = 16;
   localparam int CMDSZ  = 4096 - 128;
   localparam logic [31:0] BUFADR = 32'hFED4_0080;
   localparam logic [31:0] IDW    = 32'h0002_5811;

   localparam logic [6:0] O_LSTATE = 7'h00, O_LCTRL = 7'h08, O_LSTS = 7'h0C,
                          O_ID = 7'h30, O_REQ = 7'h40, O_STS = 7'h44,
                          O_CAN = 7'h48, O_START = 7'h4C, O_CSZ = 7'h58,
                          O_CAD = 7'h5C, O_RSZ = 7'h60, O_RAD = 7'h64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic bus_wr = 1'b0;
   logic [1:0] bus_size = 2'd3;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [LEN_W-1:0] hdr_len = '0, be_buf_size = '0, req_len;
   logic req_stb, cancel_stb;
   logic cmp_valid = 1'b0, cmp_err = 1'b0;

   int n_cmp = 0, n_bad = 0;
   logic seen_req, seen_can;

   always #2.5 clk = ~clk;

   crb_regs dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .hdr_len(hdr_len), .be_buf_size(be_buf_size), .req_stb(req_stb),
      .req_len(req_len), .cancel_stb(cancel_stb), .cmp_valid(cmp_valid),
      .cmp_err(cmp_err)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // write, then sample strobes in the cycle after the write edge
   task automatic wr(logic [6:0] a, logic [31:0] d, logic [1:0] sz = 2'd3);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_size = 2'd3;
      seen_req = req_stb; seen_can = cancel_stb;
   endtask

   task automatic rd(logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic complete(logic err);
      @(negedge clk);
      cmp_valid = 1'b1; cmp_err = err;
      @(negedge clk);
      cmp_valid = 1'b0; cmp_err = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] idle_exp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(O_START, v);  check("R1 reset start", v, 0);
      rd(O_STS, v);    check("R5 reset ctrl sts", v, 0);
      rd(O_LSTS, v);   check("R6 reset loc sts", v, 0);
      rd(O_LSTATE, v); check("R6 reset loc state", v, 0);
      check("R1 reset req_stb", {31'd0, req_stb}, 0);
      check("R3 reset cancel_stb", {31'd0, cancel_stb}, 0);

      // R8 / R9 identity and byte-lane reads
      for (int k = 0; k < 4; k++) begin
         rd(O_ID + 7'(k), v);  check("R8 R9 intf id", v, IDW >> (8 * k));
         rd(O_CAD + 7'(k), v); check("R9 R10 cmd addr", v, BUFADR >> (8 * k));
      end
      rd(O_CSZ, v); check("R10 cmd size", v, CMDSZ);
      rd(O_RSZ, v); check("R10 rsp size", v, CMDSZ);
      rd(O_RAD, v); check("R10 rsp addr", v, BUFADR);

      // R12 undefined reads and dropped writes
      rd(7'h70, v); check("R12 undefined read", v, 0);
      wr(O_ID, 32'hFFFF_FFFF); rd(O_ID, v); check("R12 ro write dropped", v, IDW);
      wr(O_CSZ, 32'h0); rd(O_CSZ, v); check("R12 ro write dropped", v, CMDSZ);
      wr(7'h70, 32'h1); rd(7'h70, v); check("R12 undefined write", v, 0);
      // non-full or misaligned start writes
      for (int s = 0; s < 3; s++) begin
         wr(O_START, 32'h1, 2'(s));
         check("R12 short start no req", {31'd0, seen_req}, 0);
      end
      wr(O_START + 7'd1, 32'h1); check("R12 misaligned start", {31'd0, seen_req}, 0);
      wr(O_START, 32'h3); check("R12 inexact start", {31'd0, seen_req}, 0);
      rd(O_START, v); check("R12 start still clear", v, 0);

      // R3 cancel while idle
      wr(O_CAN, 32'h1); check("R3 cancel idle no pulse", {31'd0, seen_can}, 0);

      // R5 sweep over control-request values
      idle_exp = 0;
      for (int val = 0; val < 16; val++) begin
         wr(O_GO_IDLE_SEED(val), 32'(val));
         if (val == 1) idle_exp = 0;
         else if (val == 2) idle_exp = 1;
         rd(O_STS, v); check("R5 ctrl req sweep", v, idle_exp << 1);
         if (val == 3) begin
            wr(O_REQ, 32'h2); rd(O_STS, v); check("R5 go idle", v, 32'h2);
            wr(O_REQ, 32'h5); rd(O_STS, v); check("R5 other ignored", v, 32'h2);
            wr(O_REQ, 32'h1); rd(O_STS, v); check("R5 cmd ready", v, 32'h0);
            idle_exp = 0;
         end
      end

      // R7 locality values other than 1
      for (int val = 0; val < 16; val++) begin
         if (val == 1) continue;
         wr(O_LCTRL, 32'(val));
         rd(O_LSTS, v);   check("R7 loc sts unchanged", v, 0);
         rd(O_LSTATE, v); check("R7 loc state unchanged", v, 0);
      end
      // R6 request access
      wr(O_LCTRL, 32'h1);
      rd(O_LSTS, v);   check("R6 granted", v, 32'h1);
      rd(O_LSTATE, v); check("R6 assigned valid", v, 32'h3);
      wr(O_LCTRL, 32'h2); rd(O_LSTS, v); check("R7 relinquish no effect", v, 32'h1);
      wr(O_LCTRL, 32'h8); rd(O_LSTATE, v); check("R7 reset est no effect", v, 32'h3);

      // R1 R2 R3 R4 R11 command flow over a length grid
      begin
         int hv[5] = '{0, 10, CMDSZ, 5000, 65535};
         int bv[5] = '{0, 100, CMDSZ, 4000, 65535};
         for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
               int eff, exp_len;
               eff = (bv[j] < CMDSZ) ? bv[j] : CMDSZ;
               exp_len = (hv[i] < eff) ? hv[i] : eff;
               hdr_len = LEN_W'(hv[i]); be_buf_size = LEN_W'(bv[j]);
               wr(O_START, 32'h1);
               check("R1 req pulse", {31'd0, seen_req}, 1);
               check("R11 req len", {16'd0, req_len}, exp_len);
               @(negedge clk);
               check("R1 single pulse", {31'd0, req_stb}, 0);
               rd(O_START, v); check("R1 busy set", v, 1);
               hdr_len = 16'd7; be_buf_size = 16'd7;
               wr(O_START, 32'h1); check("R2 start ignored", {31'd0, seen_req}, 0);
               check("R2 len held", {16'd0, req_len}, exp_len);
               wr(O_CAN, 32'h1); check("R3 cancel while busy", {31'd0, seen_can}, 1);
               complete(1'b0);
               rd(O_START, v); check("R4 completion clears", v, 0);
               rd(O_STS, v); check("R4 no fatal", v, 0);
               wr(O_CAN, 32'h1); check("R3 cancel after done", {31'd0, seen_can}, 0);
            end
         end
      end

      // R4 error completion
      wr(O_START, 32'h1);
      complete(1'b1);
      rd(O_STS, v); check("R4 fatal set", v, 32'h1);
      rd(O_START, v); check("R4 cleared on err", v, 0);
      wr(O_START, 32'h1); check("R1 restart after err", {31'd0, seen_req}, 1);
      complete(1'b0);
      rd(O_STS, v); check("R4 fatal sticky", v, 32'h1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   function automatic logic [6:0] O_GO_IDLE_SEED(int val);
      return (val >= 0) ? O_REQ : O_REQ;
   endfunction
endmodule